// File: doc/BRIEF.md
# Line clamp and calibration gating

This block sits between the sensor line-timing inputs and the analog front end of an image digitizer. It runs on the pixel clock, one clock per pixel, and turns four timing inputs into internal strobes. The calibration window and the clamp pulse become a DC-restore enable and a black-level calibration gate. The black and video sample strobes become normalised sample phases and drive a reset-reject switch enable. Each input has its own polarity select.

Two line-timing modes are supported. In the two-signal mode, the clamp input drives DC restore, qualified by the video sample phase, and the calibration window gates calibration only. In the single-window mode, the calibration window alone does both jobs. Its first four pixels restore DC and its later pixels gate calibration. The clamp input is then free to serve as a pre-blanking input that holds the reset-reject switch open. Two sticky flags report misuse: a window too short for the single-window mode, and an overlap of the clamp and the calibration window.

Top module: `line_clamp_gate`

## Requirements
- R1: While rst_ni is low and after its release with idle inputs, every output is 0.
- R2: Each of cal_i, clamp_i, sblk_i and spix_i is active high when its polarity input is 1 and active low when it is 0. blk_smp_o and pix_smp_o show the active state of sblk_i and spix_i.
- R3: With clamp_cal_mode_i = 1, dc_restore_o is 1 for a pixel exactly when both the clamp and the video sample input are active in that pixel.
- R4: With clamp_cal_mode_i = 1, cal_gate_o follows the active calibration window pixel by pixel, whatever its length, and a short window sets no flag.
- R5: With clamp_cal_mode_i = 0, the first 4 pixels of a calibration window give dc_restore_o and every later pixel of that window gives cal_gate_o. The two are never 1 together.
- R6: With clamp_cal_mode_i = 0, a window of fewer than 5 pixels sets short_err_o when it ends, and cal_gate_o is never raised for it. A window of exactly 5 pixels sets no flag. short_err_o stays 1 until reset.
- R7: A pixel where the calibration window and the clamp are both active sets overlap_err_o, which stays 1 until reset. dc_restore_o and cal_gate_o are 0 for that pixel.
- R8: With clamp_cal_mode_i = 0, rej_open_o is 1 for every pixel in which the clamp is active, whatever rej_en_i is.
- R9: With clamp_cal_mode_i = 1 and rej_en_i = 0, rej_open_o stays 0.
- R10: With rej_en_i = 1, rej_open_o is 1 from the first pixel after the video sample input stops being active, up to the next pixel in which the black sample input is active. It is 0 in that black sample pixel.
- R11: Each output reflects the pixel presented two rising clock edges earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cal_i | input | 1 | Calibration window input |
| clamp_i | input | 1 | Clamp / pre-blanking input |
| sblk_i | input | 1 | Black sample strobe |
| spix_i | input | 1 | Video sample strobe |
| cal_pol_i | input | 1 | 1 = cal_i active high |
| clamp_pol_i | input | 1 | 1 = clamp_i active high |
| sblk_pol_i | input | 1 | 1 = sblk_i active high |
| spix_pol_i | input | 1 | 1 = spix_i active high |
| clamp_cal_mode_i | input | 1 | 1 = two-signal mode, 0 = single-window mode |
| rej_en_i | input | 1 | 1 = reset-reject switch opens between samples |
| dc_restore_o | output | 1 | DC-restore enable |
| cal_gate_o | output | 1 | Black-level calibration gate |
| rej_open_o | output | 1 | Reset-reject switch open |
| blk_smp_o | output | 1 | Normalised black sample phase |
| pix_smp_o | output | 1 | Normalised video sample phase |
| overlap_err_o | output | 1 | Sticky clamp/window overlap flag |
| short_err_o | output | 1 | Sticky short window flag |

## Verification
Every output, both flags included, is due two rising edges after the pixel that causes it. One edge registers the polarity-corrected inputs, and the second registers the decoded strobes. The bench changes inputs on falling edges and holds a pixel's expectation until the next pixel has been driven, so each comparison falls on the falling edge after the second register. The one latency check samples a single-pixel window after one edge and again after two. The flags are read two idle pixels after the window ends and again some pixels later, to show they hold.

// File: rtl/ltc_pkg.sv
package ltc_pkg;
  typedef struct packed {
    logic cal;
    logic clamp;
    logic sblk;
    logic spix;
  } ltc_line_t;

  localparam int unsigned LTC_NUM_IN = 4;
endpackage

// File: rtl/ltc_in_stage.sv
module ltc_in_stage #(
  parameter int unsigned N = 4
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] raw_i,
  input  logic [N-1:0] pol_i,
  output logic [N-1:0] act_o
);
  for (genvar g = 0; g < N; g++) begin : g_in
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) act_o[g] <= 1'b0;
      else         act_o[g] <= raw_i[g] ~^ pol_i[g];
    end
  end
endmodule

// File: rtl/ltc_cal_window.sv
module ltc_cal_window #(
  parameter int unsigned DC_PIX  = 4,
  parameter int unsigned CAL_MIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cal_i,
  output logic dc_win_o,
  output logic cal_win_o,
  output logic short_o
);
  localparam int unsigned CNT_W = $clog2(CAL_MIN + 1);
  localparam logic [CNT_W-1:0] DC_LIM  = CNT_W'(DC_PIX);
  localparam logic [CNT_W-1:0] MIN_LIM = CNT_W'(CAL_MIN);

  // number of window pixels already seen, saturating
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!cal_i)           cnt_q <= '0;
    else if (cnt_q != MIN_LIM) cnt_q <= cnt_q + 1'b1;
  end

  assign dc_win_o  = cal_i && (cnt_q < DC_LIM);
  assign cal_win_o = cal_i && (cnt_q >= DC_LIM);
  assign short_o   = !cal_i && (cnt_q != '0) && (cnt_q < MIN_LIM);
endmodule

// File: rtl/ltc_rej_ctrl.sv
module ltc_rej_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic sblk_i,
  input  logic spix_i,
  output logic open_o
);
  logic spix_q, open_q;

  // opens on the pixel after video sampling ends, closes on black sampling
  assign open_o = en_i && !sblk_i && (open_q || (spix_q && !spix_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      spix_q <= 1'b0;
      open_q <= 1'b0;
    end else begin
      spix_q <= spix_i;
      open_q <= open_o;
    end
  end
endmodule

// File: rtl/line_clamp_gate.sv
module line_clamp_gate #(
  parameter int unsigned DC_PIX  = 4,
  parameter int unsigned CAL_MIN = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic cal_i,
  input  logic clamp_i,
  input  logic sblk_i,
  input  logic spix_i,
  input  logic cal_pol_i,
  input  logic clamp_pol_i,
  input  logic sblk_pol_i,
  input  logic spix_pol_i,
  input  logic clamp_cal_mode_i,
  input  logic rej_en_i,
  output logic dc_restore_o,
  output logic cal_gate_o,
  output logic rej_open_o,
  output logic blk_smp_o,
  output logic pix_smp_o,
  output logic overlap_err_o,
  output logic short_err_o
);
  import ltc_pkg::*;

  ltc_line_t act;
  logic [LTC_NUM_IN-1:0] act_vec;
  logic dc_win, cal_win, short_evt, rej_win;
  logic overlap, dc_d, gate_d, rej_d;

  ltc_in_stage #(.N(LTC_NUM_IN)) u_in (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({cal_i, clamp_i, sblk_i, spix_i}),
    .pol_i  ({cal_pol_i, clamp_pol_i, sblk_pol_i, spix_pol_i}),
    .act_o  (act_vec)
  );
  assign act = ltc_line_t'(act_vec);

  ltc_cal_window #(.DC_PIX(DC_PIX), .CAL_MIN(CAL_MIN)) u_win (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .cal_i     (act.cal),
    .dc_win_o  (dc_win),
    .cal_win_o (cal_win),
    .short_o   (short_evt)
  );

  ltc_rej_ctrl u_rej (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (rej_en_i),
    .sblk_i (act.sblk),
    .spix_i (act.spix),
    .open_o (rej_win)
  );

  assign overlap = act.cal && act.clamp;

  always_comb begin
    if (overlap) begin
      dc_d   = 1'b0;
      gate_d = 1'b0;
    end else if (clamp_cal_mode_i) begin
      dc_d   = act.clamp && act.spix;
      gate_d = act.cal;
    end else begin
      dc_d   = dc_win;
      gate_d = cal_win;
    end
    // single-window mode: clamp acts as pre-blanking
    rej_d = (!clamp_cal_mode_i && act.clamp) || rej_win;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dc_restore_o  <= 1'b0;
      cal_gate_o    <= 1'b0;
      rej_open_o    <= 1'b0;
      blk_smp_o     <= 1'b0;
      pix_smp_o     <= 1'b0;
      overlap_err_o <= 1'b0;
      short_err_o   <= 1'b0;
    end else begin
      dc_restore_o  <= dc_d;
      cal_gate_o    <= gate_d;
      rej_open_o    <= rej_d;
      blk_smp_o     <= act.sblk;
      pix_smp_o     <= act.spix;
      overlap_err_o <= overlap_err_o || overlap;
      short_err_o   <= short_err_o || (!clamp_cal_mode_i && short_evt);
    end
  end
endmodule

// File: rtl/ltc_chk.sv
module ltc_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic spix_i,
  input logic spix_pol_i,
  input logic clamp_cal_mode_i,
  input logic rej_en_i,
  input logic dc_restore_o,
  input logic cal_gate_o,
  input logic rej_open_o,
  input logic overlap_err_o,
  input logic short_err_o
);
  logic [1:0] age_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           age_q <= '0;
    else if (age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  // R7
  overlap_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overlap_err_o |=> overlap_err_o);

  // R6
  short_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    short_err_o |=> short_err_o);

  // R5
  dc_gate_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(dc_restore_o && cal_gate_o));

  // R3
  dc_needs_pix_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q == 2'd3 && dc_restore_o && $past(clamp_cal_mode_i))
      |-> ($past(spix_i, 2) ~^ $past(spix_pol_i, 2)));

  // R9
  rej_closed_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (age_q >= 2'd2 && rej_open_o) |-> ($past(rej_en_i) || !$past(clamp_cal_mode_i)));
endmodule

bind line_clamp_gate ltc_chk u_chk (.*);

// File: tb/tb_line_clamp_gate.sv
module tb_line_clamp_gate;
  logic clk_i = 1'b0;
  logic rst_ni = 1'b0;
  logic cal_i, clamp_i, sblk_i, spix_i;
  logic cal_pol_i = 1'b1, clamp_pol_i = 1'b1, sblk_pol_i = 1'b1, spix_pol_i = 1'b1;
  logic clamp_cal_mode_i = 1'b1, rej_en_i = 1'b0;
  logic dc_restore_o, cal_gate_o, rej_open_o, blk_smp_o, pix_smp_o;
  logic overlap_err_o, short_err_o;

  int checks = 0;
  int errors = 0;

  logic  pv;
  logic  p_dc, p_gt, p_rj;
  string p_tag;

  always #2.5 clk_i = ~clk_i;

  line_clamp_gate dut (.*);

  task automatic chk(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%b expected=%b", tag, act, exp);
    end
  endtask

  task automatic drive(input logic c, input logic k, input logic b, input logic s);
    cal_i   = cal_pol_i   ? c : ~c;
    clamp_i = clamp_pol_i ? k : ~k;
    sblk_i  = sblk_pol_i  ? b : ~b;
    spix_i  = spix_pol_i  ? s : ~s;
  endtask

  task automatic do_reset(input logic mode, input logic ren, input logic pol);
    @(negedge clk_i);
    rst_ni = 1'b0;
    cal_pol_i = pol; clamp_pol_i = pol; sblk_pol_i = pol; spix_pol_i = pol;
    clamp_cal_mode_i = mode;
    rej_en_i = ren;
    drive(0, 0, 0, 0);
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1'b1;
    pv = 1'b0;
  endtask

  // one pixel; expectations compared after the following pixel is driven
  task automatic step(input logic c, input logic k, input logic b, input logic s,
                      input logic e_dc, input logic e_gt, input logic e_rj, input string tag);
    drive(c, k, b, s);
    @(negedge clk_i);
    if (pv) begin
      chk({p_tag, " dc"},   dc_restore_o, p_dc);
      chk({p_tag, " gate"}, cal_gate_o,   p_gt);
      chk({p_tag, " rej"},  rej_open_o,   p_rj);
    end
    p_dc = e_dc; p_gt = e_gt; p_rj = e_rj; p_tag = tag; pv = 1'b1;
  endtask

  task automatic t_reset;
    do_reset(1, 0, 1);
    chk("R1 dc", dc_restore_o, 0);
    chk("R1 gate", cal_gate_o, 0);
    chk("R1 rej", rej_open_o, 0);
    chk("R1 blk", blk_smp_o, 0);
    chk("R1 pix", pix_smp_o, 0);
    chk("R1 ovl", overlap_err_o, 0);
    chk("R1 short", short_err_o, 0);
  endtask

  task automatic t_latency;
    do_reset(1, 0, 1);
    drive(1, 0, 0, 0);
    @(negedge clk_i);
    drive(0, 0, 0, 0);
    chk("R11 one edge", cal_gate_o, 0);
    @(negedge clk_i);
    chk("R11 two edges", cal_gate_o, 1);
    @(negedge clk_i);
    chk("R11 window over", cal_gate_o, 0);
  endtask

  task automatic t_clamp_cal;
    do_reset(1, 0, 1);
    step(0, 1, 0, 1, 1, 0, 0, "R3 clamp+pix");
    step(0, 1, 0, 0, 0, 0, 0, "R3 clamp no pix");
    step(0, 1, 0, 1, 1, 0, 0, "R3 clamp+pix again");
    step(1, 0, 0, 1, 0, 1, 0, "R4 cal px0");
    step(1, 0, 0, 0, 0, 1, 0, "R4 cal px1");
    step(0, 0, 0, 1, 0, 0, 0, "R9 idle");
    step(0, 0, 0, 0, 0, 0, 0, "R9 idle2");
    step(0, 0, 0, 0, 0, 0, 0, "R4 flush");
    chk("R4 no short flag", short_err_o, 0);
  endtask

  task automatic t_cal_only;
    do_reset(0, 0, 1);
    for (int i = 0; i < 5; i++)
      step(1, 0, 0, 0, i < 4, i >= 4, 0, "R5 window5");
    step(0, 0, 0, 0, 0, 0, 0, "R5 end");
    step(0, 0, 0, 0, 0, 0, 0, "R5 flush");
    chk("R6 exact 5 no flag", short_err_o, 0);
    for (int i = 0; i < 4; i++)
      step(1, 0, 0, 0, 1, 0, 0, "R6 window4 no gate");
    step(0, 0, 0, 0, 0, 0, 0, "R6 end");
    step(0, 0, 0, 0, 0, 0, 0, "R6 flush");
    chk("R6 short flag", short_err_o, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, "R6 idle");
    chk("R6 short sticky", short_err_o, 1);
  endtask

  task automatic t_polarity;
    do_reset(0, 0, 0);
    chk("R2 idle low-active", cal_gate_o, 0);
    for (int i = 0; i < 6; i++)
      step(1, 0, 0, 0, i < 4, i >= 4, 0, "R2 cal active low");
    step(0, 0, 0, 0, 0, 0, 0, "R2 end");
    step(0, 0, 0, 0, 0, 0, 0, "R2 flush");
    drive(0, 0, 1, 0);
    @(negedge clk_i);
    drive(0, 0, 0, 1);
    @(negedge clk_i);
    chk("R2 blk smp", blk_smp_o, 1);
    chk("R2 pix smp idle", pix_smp_o, 0);
    drive(0, 0, 0, 0);
    @(negedge clk_i);
    chk("R2 pix smp", pix_smp_o, 1);
    chk("R2 blk smp idle", blk_smp_o, 0);
  endtask

  task automatic t_preblank;
    do_reset(0, 0, 1);
    for (int i = 0; i < 3; i++) step(0, 1, 0, 1, 0, 0, 1, "R8 preblank");
    step(0, 0, 0, 0, 0, 0, 0, "R8 released");
    step(0, 0, 0, 0, 0, 0, 0, "R8 flush");
  endtask

  task automatic t_rej;
    do_reset(1, 1, 1);
    step(0, 0, 1, 0, 0, 0, 0, "R10 blk");
    step(0, 0, 0, 1, 0, 0, 0, "R10 pix");
    step(0, 0, 0, 0, 0, 0, 1, "R10 after pix");
    step(0, 0, 0, 0, 0, 0, 1, "R10 hold open");
    step(0, 0, 1, 0, 0, 0, 0, "R10 next blk");
    step(0, 0, 0, 0, 0, 0, 0, "R10 closed");
    step(0, 0, 0, 0, 0, 0, 0, "R10 flush");
    do_reset(1, 0, 1);
    step(0, 0, 0, 1, 0, 0, 0, "R9 pix");
    step(0, 0, 0, 0, 0, 0, 0, "R9 after pix");
    step(0, 0, 0, 0, 0, 0, 0, "R9 flush");
  endtask

  task automatic t_overlap;
    do_reset(1, 0, 1);
    step(1, 1, 0, 1, 0, 0, 0, "R7 overlap");
    step(0, 0, 0, 0, 0, 0, 0, "R7 end");
    step(0, 0, 0, 0, 0, 0, 0, "R7 flush");
    chk("R7 flag", overlap_err_o, 1);
    for (int i = 0; i < 4; i++) step(0, 0, 0, 0, 0, 0, 0, "R7 idle");
    chk("R7 sticky", overlap_err_o, 1);
    do_reset(0, 0, 1);
    step(1, 1, 0, 0, 0, 0, 1, "R7 overlap single-window");
    step(0, 0, 0, 0, 0, 0, 0, "R7 end2");
    step(0, 0, 0, 0, 0, 0, 0, "R7 flush2");
    chk("R7 flag single-window", overlap_err_o, 1);
  endtask

  initial begin
    pv = 1'b0;
    drive(0, 0, 0, 0);
    t_reset();
    t_latency();
    t_clamp_cal();
    t_cal_only();
    t_polarity();
    t_preblank();
    t_rej();
    t_overlap();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule